// File: doc/BRIEF.md
# Burst Length Equalizer with Response Merging

This block sits between one bus master and a shared memory interconnect. Any read or write burst that is longer than a common limit `b` is cut into consecutive sub-bursts of at most `b` beats each. The final sub-burst carries whatever beats remain. Every master behind such a block therefore presents bursts of the same maximum size to the arbiter, and round-robin arbitration then shares bandwidth evenly.

The master never sees the split. Read beats flow back in order, and the last-beat flag is raised only once, on the final beat of the original burst. Write data is forwarded beat by beat, and a last-beat flag is inserted downstream at the end of every sub-burst. The write responses of all the sub-bursts are folded into a single response that carries the worst code. The limit `b` is a runtime input. It is captured into an internal register only while neither direction has a burst in flight, so a burst is always split with one consistent size.

Each direction handles one burst at a time. The address channel towards the interconnect is registered. Data and response beats pass through with only gating logic. All bursts are incrementing, and each beat is `DATA_W/8` bytes wide.

Top module: `beq_burst_equalizer`

## Requirements
- R1: A burst of N beats (N = len+1, 1..256) accepted while the active size is b (b = cfg_sub_len+1) leaves as ceil(N/b) downstream bursts. Every one except the last is b beats long. The last one carries N - b*(ceil(N/b)-1) beats. A burst with N <= b leaves unchanged.
- R2: Sub-burst k (counting from 0) starts at the original address plus k*b*(DATA_W/8). A downstream address request holds its address and length stable until it is accepted.
- R3: Read beats reach the master in downstream order, with data and response unchanged. s_rlast is 1 only on beat N-1 of the original burst, and exactly N beats are returned.
- R4: Write beats leave downstream in master order, with data and strobes unchanged. m_wlast is 1 on beat j (counting from 0) exactly when j mod b = b-1 or j = N-1.
- R5: Exactly one write response is returned per master burst, after every sub-response has arrived. Its code is the largest of the sub-response codes under the ordering OKAY(0) < EXOKAY(1) < SLVERR(2) < DECERR(3). It holds stable until the master accepts it.
- R6: cfg_sub_len is copied into the active size on every cycle in which neither direction is busy. A change made while a burst is in flight does not affect that burst, and it applies to bursts accepted after both directions return to idle.
- R7: After reset, s_arready and s_awready are 1, and m_arvalid, m_awvalid and s_bvalid are 0.
- R8: Each direction holds one burst at a time. After an address handshake on the master side, that direction's ready stays 0 until the burst has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sub_len | input | LEN_W | Common sub-burst size minus one |
| s_araddr | input | ADDR_W | Master read address |
| s_arlen | input | LEN_W | Master read length minus one |
| s_arvalid | input | 1 | Master read request valid |
| s_arready | output | 1 | Read request accepted |
| s_rdata | output | DATA_W | Read data to master |
| s_rresp | output | 2 | Read response code to master |
| s_rlast | output | 1 | Final beat of the master's burst |
| s_rvalid | output | 1 | Read beat valid |
| s_rready | input | 1 | Master accepts read beat |
| s_awaddr | input | ADDR_W | Master write address |
| s_awlen | input | LEN_W | Master write length minus one |
| s_awvalid | input | 1 | Master write request valid |
| s_awready | output | 1 | Write request accepted |
| s_wdata | input | DATA_W | Master write data |
| s_wstrb | input | DATA_W/8 | Master byte strobes |
| s_wvalid | input | 1 | Write beat valid |
| s_wready | output | 1 | Write beat accepted |
| s_bresp | output | 2 | Merged write response code |
| s_bvalid | output | 1 | Merged response valid |
| s_bready | input | 1 | Master accepts response |
| m_araddr | output | ADDR_W | Sub-burst read address |
| m_arlen | output | LEN_W | Sub-burst read length minus one |
| m_arvalid | output | 1 | Sub-burst read request valid |
| m_arready | input | 1 | Interconnect accepts read request |
| m_rdata | input | DATA_W | Read data from interconnect |
| m_rresp | input | 2 | Read response code from interconnect |
| m_rvalid | input | 1 | Read beat valid from interconnect |
| m_rready | output | 1 | Read beat accepted |
| m_awaddr | output | ADDR_W | Sub-burst write address |
| m_awlen | output | LEN_W | Sub-burst write length minus one |
| m_awvalid | output | 1 | Sub-burst write request valid |
| m_awready | input | 1 | Interconnect accepts write request |
| m_wdata | output | DATA_W | Write data downstream |
| m_wstrb | output | DATA_W/8 | Byte strobes downstream |
| m_wlast | output | 1 | Last beat of the current sub-burst |
| m_wvalid | output | 1 | Write beat valid downstream |
| m_wready | input | 1 | Interconnect accepts write beat |
| m_bresp | input | 2 | Sub-burst write response code |
| m_bvalid | input | 1 | Sub-burst response valid |
| m_bready | output | 1 | Sub-burst response accepted |

## Verification
Bursts of every length from 1 to 20 beats are sent in both directions under sizes of 1, 2, 3, 4 and 8. This covers exact multiples of b, remainders of every size, and bursts shorter than b that must pass through unsplit. The 256-beat bursts under sizes of 256 and 128 exercise the widest length and the counter that holds one more than a length field. The downstream ready signals and the master valid and ready signals stall on different periodic patterns, so address, data and response timing are decoupled from one another. Sub-response codes are drawn from a mix in which some bursts see only OKAY and others see EXOKAY, SLVERR or DECERR, which separates a true worst-of merge from one that keeps the first or the last code. The size is also changed in the middle of a burst, to show that the running burst keeps its old size and the next burst picks up the new one.

// File: rtl/beq_pkg.sv
package beq_pkg;
  typedef enum logic [1:0] {
    RSP_OKAY   = 2'd0,
    RSP_EXOKAY = 2'd1,
    RSP_SLVERR = 2'd2,
    RSP_DECERR = 2'd3
  } rsp_e;

  // Severity follows the numeric code: DECERR > SLVERR > EXOKAY > OKAY
  function automatic logic [1:0] rsp_worst(input logic [1:0] a, input logic [1:0] b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/beq_addr_gen.sv
// Issues the chain of sub-burst requests for one master burst.
module beq_addr_gen #(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 8,
  parameter int BYTES_LG = 2,
  localparam int CNT_W   = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [CNT_W-1:0]  st_beats,
  input  logic [CNT_W-1:0]  st_b,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [LEN_W-1:0]  out_len
);
  logic              vld;
  logic [ADDR_W-1:0] addr;
  logic [LEN_W-1:0]  len;
  logic [CNT_W-1:0]  rem, bcur;
  logic [CNT_W-1:0]  pick_rem, pick_b, chunk, chunk_m1, cur_beats;
  logic [ADDR_W-1:0] step;

  always_comb begin
    pick_rem  = start ? st_beats : rem;
    pick_b    = start ? st_b : bcur;
    chunk     = (pick_rem < pick_b) ? pick_rem : pick_b;
    chunk_m1  = chunk - CNT_W'(1);
    cur_beats = {1'b0, len} + CNT_W'(1);
    step      = ADDR_W'(cur_beats) << BYTES_LG;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld  <= 1'b0;
      addr <= '0;
      len  <= '0;
      rem  <= '0;
      bcur <= CNT_W'(1);
    end else if (start) begin
      vld  <= 1'b1;
      bcur <= st_b;
      addr <= st_addr;
      len  <= chunk_m1[LEN_W-1:0];
      rem  <= st_beats - chunk;
    end else if (vld && out_ready) begin
      if (rem != '0) begin
        addr <= addr + step;
        len  <= chunk_m1[LEN_W-1:0];
        rem  <= rem - chunk;
      end else begin
        vld <= 1'b0;
      end
    end
  end

  assign out_valid = vld;
  assign out_addr  = addr;
  assign out_len   = len;
endmodule

// File: rtl/beq_rd_path.sv
// Read direction: splits the request, relays beats, masks early last flags.
module beq_rd_path #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int LEN_W    = 8,
  parameter int BYTES_LG = 2,
  localparam int CNT_W   = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  b_act,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic [LEN_W-1:0]  s_arlen,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rlast,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [ADDR_W-1:0] m_araddr,
  output logic [LEN_W-1:0]  m_arlen,
  output logic              m_arvalid,
  input  logic              m_arready,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic [1:0]        m_rresp,
  input  logic              m_rvalid,
  output logic              m_rready,
  output logic              busy
);
  logic             start;
  logic [CNT_W-1:0] beats, r_rem;

  assign start     = s_arvalid && !busy;
  assign beats     = {1'b0, s_arlen} + CNT_W'(1);
  assign s_arready = !busy;

  beq_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BYTES_LG(BYTES_LG)) u_gen (
    .clk(clk), .rst(rst), .start(start), .st_addr(s_araddr), .st_beats(beats),
    .st_b(b_act), .out_ready(m_arready), .out_valid(m_arvalid),
    .out_addr(m_araddr), .out_len(m_arlen)
  );

  assign m_rready = busy && s_rready;
  assign s_rvalid = busy && m_rvalid;
  assign s_rdata  = m_rdata;
  assign s_rresp  = m_rresp;
  assign s_rlast  = (r_rem == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      r_rem <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      r_rem <= beats;
    end else if (m_rvalid && m_rready) begin
      r_rem <= r_rem - CNT_W'(1);
      if (r_rem == CNT_W'(1)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/beq_wr_path.sv
// Write direction: splits the request, marks sub-burst ends, folds responses.
module beq_wr_path
  import beq_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int LEN_W    = 8,
  parameter int BYTES_LG = 2,
  localparam int CNT_W   = LEN_W + 1,
  localparam int STRB_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  b_act,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic [LEN_W-1:0]  s_awlen,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [STRB_W-1:0] s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [ADDR_W-1:0] m_awaddr,
  output logic [LEN_W-1:0]  m_awlen,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [DATA_W-1:0] m_wdata,
  output logic [STRB_W-1:0] m_wstrb,
  output logic              m_wlast,
  output logic              m_wvalid,
  input  logic              m_wready,
  input  logic [1:0]        m_bresp,
  input  logic              m_bvalid,
  output logic              m_bready,
  output logic              busy
);
  logic             start, w_open;
  logic [CNT_W-1:0] beats, w_rem, w_pos, wb, aw_cnt, b_cnt;
  logic [1:0]       acc, merged;
  logic             bvld;
  logic [1:0]       bresp_q;

  assign start     = s_awvalid && !busy;
  assign beats     = {1'b0, s_awlen} + CNT_W'(1);
  assign s_awready = !busy;

  beq_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BYTES_LG(BYTES_LG)) u_gen (
    .clk(clk), .rst(rst), .start(start), .st_addr(s_awaddr), .st_beats(beats),
    .st_b(b_act), .out_ready(m_awready), .out_valid(m_awvalid),
    .out_addr(m_awaddr), .out_len(m_awlen)
  );

  assign w_open   = busy && (w_rem != '0);
  assign m_wvalid = w_open && s_wvalid;
  assign s_wready = w_open && m_wready;
  assign m_wdata  = s_wdata;
  assign m_wstrb  = s_wstrb;
  assign m_wlast  = (w_pos == wb - CNT_W'(1)) || (w_rem == CNT_W'(1));

  assign m_bready = busy && !bvld;
  assign merged   = rsp_worst(acc, m_bresp);
  assign s_bvalid = bvld;
  assign s_bresp  = bresp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      w_rem   <= '0;
      w_pos   <= '0;
      wb      <= CNT_W'(1);
      aw_cnt  <= '0;
      b_cnt   <= '0;
      acc     <= RSP_OKAY;
      bvld    <= 1'b0;
      bresp_q <= RSP_OKAY;
    end else if (start) begin
      busy   <= 1'b1;
      w_rem  <= beats;
      w_pos  <= '0;
      wb     <= b_act;
      aw_cnt <= '0;
      b_cnt  <= '0;
      acc    <= RSP_OKAY;
    end else begin
      if (m_awvalid && m_awready) aw_cnt <= aw_cnt + CNT_W'(1);
      if (m_wvalid && m_wready) begin
        w_rem <= w_rem - CNT_W'(1);
        w_pos <= m_wlast ? '0 : w_pos + CNT_W'(1);
      end
      if (m_bvalid && m_bready) begin
        b_cnt <= b_cnt + CNT_W'(1);
        acc   <= merged;
        if (!m_awvalid && (b_cnt + CNT_W'(1) == aw_cnt)) begin
          bvld    <= 1'b1;
          bresp_q <= merged;
        end
      end
      if (bvld && s_bready) begin
        bvld <= 1'b0;
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/beq_burst_equalizer.sv
module beq_burst_equalizer #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8,
  parameter int DEF_B  = 16,
  localparam int CNT_W    = LEN_W + 1,
  localparam int STRB_W   = DATA_W / 8,
  localparam int BYTES_LG = $clog2(STRB_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LEN_W-1:0]  cfg_sub_len,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic [LEN_W-1:0]  s_arlen,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rlast,
  output logic              s_rvalid,
  input  logic              s_rready,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic [LEN_W-1:0]  s_awlen,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [STRB_W-1:0] s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [ADDR_W-1:0] m_araddr,
  output logic [LEN_W-1:0]  m_arlen,
  output logic              m_arvalid,
  input  logic              m_arready,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic [1:0]        m_rresp,
  input  logic              m_rvalid,
  output logic              m_rready,
  output logic [ADDR_W-1:0] m_awaddr,
  output logic [LEN_W-1:0]  m_awlen,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [DATA_W-1:0] m_wdata,
  output logic [STRB_W-1:0] m_wstrb,
  output logic              m_wlast,
  output logic              m_wvalid,
  input  logic              m_wready,
  input  logic [1:0]        m_bresp,
  input  logic              m_bvalid,
  output logic              m_bready
);
  logic [CNT_W-1:0] b_act;
  logic             rd_busy, wr_busy;

  // Active size is refreshed only while nothing is in flight
  always_ff @(posedge clk) begin
    if (rst)                      b_act <= CNT_W'(DEF_B);
    else if (!rd_busy && !wr_busy) b_act <= {1'b0, cfg_sub_len} + CNT_W'(1);
  end

  beq_rd_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .BYTES_LG(BYTES_LG)) u_rd (
    .clk(clk), .rst(rst), .b_act(b_act),
    .s_araddr(s_araddr), .s_arlen(s_arlen), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rlast(s_rlast), .s_rvalid(s_rvalid),
    .s_rready(s_rready),
    .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arvalid(m_arvalid), .m_arready(m_arready),
    .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rvalid(m_rvalid), .m_rready(m_rready),
    .busy(rd_busy)
  );

  beq_wr_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .BYTES_LG(BYTES_LG)) u_wr (
    .clk(clk), .rst(rst), .b_act(b_act),
    .s_awaddr(s_awaddr), .s_awlen(s_awlen), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awvalid(m_awvalid), .m_awready(m_awready),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast), .m_wvalid(m_wvalid),
    .m_wready(m_wready),
    .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
    .busy(wr_busy)
  );
endmodule

// File: rtl/beq_checker.sv
module beq_checker #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  localparam int CNT_W = LEN_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic [CNT_W-1:0]  b_act,
  input logic              rd_busy,
  input logic              wr_busy,
  input logic [ADDR_W-1:0] m_araddr,
  input logic [LEN_W-1:0]  m_arlen,
  input logic              m_arvalid,
  input logic              m_arready,
  input logic [LEN_W-1:0]  m_awlen,
  input logic              m_awvalid,
  input logic              s_arvalid,
  input logic              s_arready,
  input logic [1:0]        s_bresp,
  input logic              s_bvalid,
  input logic              s_bready
);
  assert_ar_len_R1: assert property (@(posedge clk) disable iff (rst)
    m_arvalid |-> ({1'b0, m_arlen} < b_act));

  assert_aw_len_R1: assert property (@(posedge clk) disable iff (rst)
    m_awvalid |-> ({1'b0, m_awlen} < b_act));

  assert_ar_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (m_arvalid && !m_arready) |=> (m_arvalid && $stable(m_araddr) && $stable(m_arlen)));

  assert_bresp_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bresp)));

  assert_size_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_busy || wr_busy) |=> $stable(b_act));

  assert_one_read_R8: assert property (@(posedge clk) disable iff (rst)
    (s_arvalid && s_arready) |=> !s_arready);
endmodule

bind beq_burst_equalizer beq_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .b_act(b_act), .rd_busy(rd_busy), .wr_busy(wr_busy),
  .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arvalid(m_arvalid), .m_arready(m_arready),
  .m_awlen(m_awlen), .m_awvalid(m_awvalid),
  .s_arvalid(s_arvalid), .s_arready(s_arready),
  .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready)
);

// File: tb/beq_burst_equalizer_tb.sv
`timescale 1ns/1ps
module beq_burst_equalizer_tb;
  localparam int AW = 32, DW = 32, LW = 8;

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [LW-1:0] cfg_sub_len = 8'd3;
  logic [AW-1:0] s_araddr = '0, s_awaddr = '0;
  logic [LW-1:0] s_arlen = '0, s_awlen = '0;
  logic s_arvalid = 0, s_rready = 0, s_awvalid = 0, s_wvalid = 0, s_bready = 0;
  logic [DW-1:0] s_wdata = '0;
  logic [3:0] s_wstrb = 4'hF;
  logic s_arready, s_rlast, s_rvalid, s_awready, s_wready, s_bvalid;
  logic [DW-1:0] s_rdata;
  logic [1:0] s_rresp, s_bresp;
  logic [AW-1:0] m_araddr, m_awaddr;
  logic [LW-1:0] m_arlen, m_awlen;
  logic m_arvalid, m_arready, m_rvalid, m_rready, m_awvalid, m_awready;
  logic m_wlast, m_wvalid, m_wready, m_bready;
  logic [DW-1:0] m_rdata, m_wdata;
  logic [3:0] m_wstrb;
  logic [1:0] m_rresp, m_bresp;
  logic m_bvalid;

  beq_burst_equalizer u_dut (.*);

  int checks = 0, fails = 0, cyc = 0;
  bit reported = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] resp_of(input int k);
    case ((k * 7 + k / 3) % 11)
      0: return 2'd2;
      5: return 2'd3;
      8: return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  // Downstream model with logs
  logic [AW-1:0] arq_a [64];
  logic [LW-1:0] arq_l [64];
  int arq_wp = 0, arq_rp = 0;
  logic r_act = 0;
  logic [AW-1:0] r_addr = '0;
  logic [LW-1:0] r_cnt = '0;
  logic [AW-1:0] aw_a [64];
  logic [LW-1:0] aw_l [64];
  logic [DW-1:0] w_d [64];
  logic w_l [64];
  int aw_n = 0, w_n = 0, wl_cnt = 0, b_sent = 0;

  assign m_arready = (cyc % 3) != 1;
  assign m_awready = (cyc % 4) != 2;
  assign m_wready  = (cyc % 5) != 4;
  assign m_rvalid  = r_act;
  assign m_rdata   = r_addr;
  assign m_rresp   = 2'd0;

  always @(posedge clk) begin
    if (rst) begin
      r_act <= 0; m_bvalid <= 0; m_bresp <= 0;
    end else begin
      if (m_arvalid && m_arready) begin
        arq_a[arq_wp % 64] <= m_araddr; arq_l[arq_wp % 64] <= m_arlen; arq_wp <= arq_wp + 1;
      end
      if (r_act) begin
        if (m_rready) begin
          if (r_cnt == 0) begin r_act <= 0; arq_rp <= arq_rp + 1; end
          else begin r_addr <= r_addr + 4; r_cnt <= r_cnt - 1; end
        end
      end else if (arq_rp != arq_wp) begin
        r_act <= 1; r_addr <= arq_a[arq_rp % 64]; r_cnt <= arq_l[arq_rp % 64];
      end
      if (m_awvalid && m_awready) begin
        aw_a[aw_n % 64] <= m_awaddr; aw_l[aw_n % 64] <= m_awlen; aw_n <= aw_n + 1;
      end
      if (m_wvalid && m_wready) begin
        w_d[w_n % 64] <= m_wdata; w_l[w_n % 64] <= m_wlast; w_n <= w_n + 1;
        if (m_wlast) wl_cnt <= wl_cnt + 1;
      end
      if (m_bvalid && m_bready) begin
        m_bvalid <= 0; b_sent <= b_sent + 1;
      end else if (!m_bvalid && b_sent < wl_cnt && b_sent < aw_n) begin
        m_bvalid <= 1; m_bresp <= resp_of(b_sent);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input int n, input int b, input int new_b);
    int base, got, t, nsub, el;
    bit done;
    base = arq_wp; got = 0; t = 0; done = 0;
    @(posedge clk); #1;
    s_araddr = a; s_arlen = LW'(n - 1); s_arvalid = 1;
    forever begin @(negedge clk); if (s_arready) break; @(posedge clk); #1; end
    @(posedge clk); #1;
    s_arvalid = 0;
    if (new_b > 0) cfg_sub_len = LW'(new_b - 1);
    @(negedge clk);
    chk(!s_arready, "R8", "read ready while busy", s_arready, 0);
    @(posedge clk); #1;
    while (!done && got <= n) begin
      s_rready = (t % 3) != 2; t++;
      @(negedge clk);
      if (s_rvalid && s_rready) begin
        chk(s_rdata == a + 4 * got, "R3", "read data", s_rdata, a + 4 * got);
        chk(s_rlast == (got == n - 1), "R3", "rlast", s_rlast, got == n - 1);
        got++;
        if (s_rlast) done = 1;
      end
      @(posedge clk); #1;
    end
    s_rready = 0;
    chk(got == n, "R3", "beat count", got, n);
    nsub = (n + b - 1) / b;
    chk(arq_wp - base == nsub, "R1", "read sub-burst count", arq_wp - base, nsub);
    for (int k = 0; k < nsub && k < 64; k++) begin
      el = ((n - k * b) < b ? (n - k * b) : b) - 1;
      chk(arq_l[(base + k) % 64] == LW'(el), "R1", "read sub length", arq_l[(base + k) % 64], el);
      chk(arq_a[(base + k) % 64] == a + k * b * 4, "R2", "read sub address",
          arq_a[(base + k) % 64], a + k * b * 4);
    end
    idle(3);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input int n, input int b, input int new_b);
    int base_aw, base_w, base_b, i, t, nsub, el;
    logic [1:0] er, got_r;
    bit exp_last;
    base_aw = aw_n; base_w = w_n; base_b = b_sent; i = 0; t = 0;
    @(posedge clk); #1;
    s_awaddr = a; s_awlen = LW'(n - 1); s_awvalid = 1;
    forever begin @(negedge clk); if (s_awready) break; @(posedge clk); #1; end
    @(posedge clk); #1;
    s_awvalid = 0;
    if (new_b > 0) cfg_sub_len = LW'(new_b - 1);
    @(negedge clk);
    chk(!s_awready, "R8", "write ready while busy", s_awready, 0);
    @(posedge clk); #1;
    while (i < n) begin
      s_wvalid = (t % 4) != 3; t++;
      s_wdata = 32'hA000_0000 + a + i;
      @(negedge clk);
      if (s_wvalid && s_wready) i++;
      @(posedge clk); #1;
    end
    s_wvalid = 0;
    s_bready = 1;
    forever begin @(negedge clk); if (s_bvalid) break; @(posedge clk); #1; end
    got_r = s_bresp;
    @(posedge clk); #1;
    s_bready = 0;
    nsub = (n + b - 1) / b;
    er = 2'd0;
    for (int k = 0; k < nsub; k++) if (resp_of(base_b + k) > er) er = resp_of(base_b + k);
    chk(got_r == er, "R5", "merged response", got_r, er);
    chk(b_sent - base_b == nsub, "R5", "sub responses consumed", b_sent - base_b, nsub);
    idle(3);
    chk(!s_bvalid, "R5", "single response", s_bvalid, 0);
    chk(aw_n - base_aw == nsub, "R1", "write sub-burst count", aw_n - base_aw, nsub);
    for (int k = 0; k < nsub; k++) begin
      el = ((n - k * b) < b ? (n - k * b) : b) - 1;
      chk(aw_l[(base_aw + k) % 64] == LW'(el), "R1", "write sub length", aw_l[(base_aw + k) % 64], el);
      chk(aw_a[(base_aw + k) % 64] == a + k * b * 4, "R2", "write sub address",
          aw_a[(base_aw + k) % 64], a + k * b * 4);
    end
    chk(w_n - base_w == n, "R4", "write beat count", w_n - base_w, n);
    for (int j = 0; j < n; j++) begin
      exp_last = ((j % b) == b - 1) || (j == n - 1);
      chk(w_d[(base_w + j) % 64] == 32'hA000_0000 + a + j, "R4", "write data",
          w_d[(base_w + j) % 64], 32'hA000_0000 + a + j);
      chk(w_l[(base_w + j) % 64] == exp_last, "R4", "wlast position",
          w_l[(base_w + j) % 64], exp_last);
    end
  endtask

  task automatic set_b(input int b);
    cfg_sub_len = LW'(b - 1);
    idle(3);
  endtask

  initial begin
    int bs [5] = '{1, 2, 3, 4, 8};
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(s_arready && s_awready, "R7", "readys after reset", {s_arready, s_awready}, 3);
    chk(!m_arvalid && !m_awvalid && !s_bvalid, "R7", "valids after reset",
        {m_arvalid, m_awvalid, s_bvalid}, 0);
    for (int bi = 0; bi < 5; bi++) begin
      set_b(bs[bi]);
      for (int n = 1; n <= 20; n++) begin
        do_read(32'h1000 + n * 256 + bs[bi] * 8192, n, bs[bi], 0);
        do_write(32'h4_0000 + n * 256 + bs[bi] * 8192, n, bs[bi], 0);
      end
    end
    // R6: size changed mid-burst applies only to later bursts
    set_b(2);
    do_read(32'h8_0000, 9, 2, 5);
    idle(2);
    do_read(32'h8_1000, 9, 5, 0);
    set_b(3);
    do_write(32'h9_0000, 10, 3, 4);
    idle(2);
    do_write(32'h9_1000, 10, 4, 0);
    // Widest length
    set_b(256);
    do_read(32'hA_0000, 256, 256, 0);
    set_b(128);
    do_read(32'hB_0000, 256, 128, 0);
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!reported) begin
      checks++; fails++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 1, 0);
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
    $finish;
  end
endmodule